// File: doc/BRIEF.md
# Serial Command and Response Engine with CRC-16

This block sits behind an SPI slave shifter and works one byte at a time. The shifter delivers each byte it receives from the host with a one-cycle strobe. At the same moment, the shifter sends out whatever byte the engine currently presents. When the engine recognises a command byte, it collects the bytes of a response from the sensing core. These come from the status byte, three event counters, the key detect flags, or the data of one selected key. The engine then appends a 16-bit CRC and presents the response one byte per host transfer.

The host clocks a response out by sending null bytes. The engine ignores any byte that arrives while an intermediate response byte is being shifted. The byte that arrives alongside the last response byte is decoded as a fresh command, so commands can be chained with no idle transfer between them. A ready line tells the host when the next byte has been loaded and it may start another transfer.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, `ready` is 1, `tx_byte` is 0x00 and the engine is idle, waiting for a command.
- R2: In the cycle after any received byte strobe, `ready` is 0. It returns to 1 once the next response byte sits on `tx_byte`, or once the engine is idle again.
- R3: The CRC uses polynomial 0x1021 and starts from 0x0000. It is computed MSB first, eight shifts per byte. The command byte is folded in first, then each response data byte in order. The CRC is sent after the data, low byte first.
- R4: Command 0x06 returns five data bytes in this order: `status_byte`, the touch summary byte, `tick_count`, `scan_count`, `fail_count`.
- R5: In the touch summary byte, bits 7:6 hold the number of keys in detect, saturating at 3. Bits 5:0 hold the lowest index among the detecting keys, or 0 when no key detects.
- R6: Command 0x07 returns ceil(NKEYS/8) data bytes. Bit i of data byte j is the detect flag of key 8*j+i.
- R7: Command 0x40+k, for k < NKEYS, drives `key_sel` to k. It returns five data bytes: signal low, signal high, reference low, reference high, integrator.
- R8: A byte received while a response byte other than the last one is shifted out has no effect on the response. The engine presents the following response byte.
- R9: The byte received while the last response byte (CRC high) is shifted out is decoded as a new command. A valid one starts its own response with no further transfer.
- R10: A null byte (0x00) or an unrecognised byte (including 0x40+NKEYS and above) received while idle, or in the last-byte position, produces no response. The engine stays idle with `tx_byte` 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a host byte has been received |
| rx_byte | input | 8 | Received host byte |
| status_byte | input | 8 | Device status byte |
| tick_count | input | 8 | 100 ms tick counter |
| scan_count | input | 8 | Matrix scan counter |
| fail_count | input | 8 | Signal fail counter |
| key_detect | input | NKEYS | Per-key detect flags |
| key_sel | output | $clog2(NKEYS) | Index of the key whose data is requested |
| key_signal | input | 16 | Signal of the selected key |
| key_ref | input | 16 | Reference of the selected key |
| key_integ | input | 8 | Integrator value of the selected key |
| tx_byte | output | 8 | Byte presented for the next host transfer |
| ready | output | 1 | Next byte loaded; host may transfer |

## Verification
The bench sweeps every per-key command, including the first one past the last key. It also applies detect patterns with no keys, one key, two keys and all keys.

- A wrong encoder or saturation would misreport which key detects first or how many keys detect.
- A CRC seeded without the command byte, or sent high byte first, would change the last two bytes of every response.
- Treating intermediate bytes as commands would cut a response short and send the wrong byte.
- Failing to decode on the last byte would break chained commands.

The bench also sends null, unknown and out-of-range bytes while idle, and checks that `tx_byte` stays 0x00.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_CRC, ST_FIN, ST_ADV, ST_SEND
  } eng_state_t;

  typedef enum logic [1:0] {
    K_NONE, K_OVR, K_ALL, K_KEY
  } cmd_kind_t;

  localparam logic [7:0] CMD_OVR  = 8'h06;
  localparam logic [7:0] CMD_ALL  = 8'h07;
  localparam logic [7:0] CMD_KEY0 = 8'h40;
endpackage

// File: rtl/crc16_fold.sv
module crc16_fold #(
  parameter logic [15:0] POLY = 16'h1021
) (
  input  logic [15:0] crc_in,
  input  logic [7:0]  data_in,
  output logic [15:0] crc_out
);
  always_comb begin
    crc_out = crc_in ^ {data_in, 8'h00};
    for (int b = 0; b < 8; b++) begin
      if (crc_out[15]) crc_out = {crc_out[14:0], 1'b0} ^ POLY;
      else             crc_out = {crc_out[14:0], 1'b0};
    end
  end
endmodule

// File: rtl/touch_summary.sv
module touch_summary #(
  parameter int NKEYS = 48
) (
  input  logic [NKEYS-1:0] det,
  output logic [7:0]       summary
);
  logic [5:0] first;
  logic [1:0] cnt;

  always_comb begin
    first = '0;
    cnt   = '0;
    for (int i = NKEYS - 1; i >= 0; i--)
      if (det[i]) first = 6'(i);
    for (int i = 0; i < NKEYS; i++)
      if (det[i] && cnt != 2'd3) cnt = cnt + 2'd1;
    summary = {cnt, first};
  end
endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder
  import spi_eng_pkg::*;
#(
  parameter int NKEYS  = 48,
  parameter int KW     = 6,
  parameter int IW     = 3,
  parameter int KBYTES = 6
) (
  input  logic [7:0]    cmd,
  output cmd_kind_t     kind,
  output logic [IW-1:0] ndata,
  output logic [KW-1:0] key
);
  logic [7:0] off;

  always_comb begin
    off   = cmd - CMD_KEY0;
    kind  = K_NONE;
    ndata = '0;
    key   = off[KW-1:0];
    if (cmd == CMD_OVR) begin
      kind  = K_OVR;
      ndata = IW'(5);
    end else if (cmd == CMD_ALL) begin
      kind  = K_ALL;
      ndata = IW'(KBYTES);
    end else if (cmd >= CMD_KEY0 && int'(off) < NKEYS) begin
      kind  = K_KEY;
      ndata = IW'(5);
    end
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_eng_pkg::*;
#(
  parameter int          NKEYS = 48,
  parameter logic [15:0] POLY  = 16'h1021,
  localparam int         KW    = $clog2(NKEYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic [7:0]       status_byte,
  input  logic [7:0]       tick_count,
  input  logic [7:0]       scan_count,
  input  logic [7:0]       fail_count,
  input  logic [NKEYS-1:0] key_detect,
  output logic [KW-1:0]    key_sel,
  input  logic [15:0]      key_signal,
  input  logic [15:0]      key_ref,
  input  logic [7:0]       key_integ,
  output logic [7:0]       tx_byte,
  output logic             ready
);
  localparam int KBYTES = (NKEYS + 7) / 8;
  localparam int NDMAX  = (KBYTES > 5) ? KBYTES : 5;
  localparam int MAXLEN = NDMAX + 2;
  localparam int IW     = $clog2(MAXLEN);

  eng_state_t    state;
  cmd_kind_t     kind_r, dec_kind;
  logic [IW-1:0] ndata_r, dec_ndata, idx;
  logic [KW-1:0] dec_key;
  logic [15:0]   crc, fold_in, fold_out;
  logic [7:0]    fold_byte, ovr_byte;
  logic [7:0]    resp [MAXLEN];
  logic [KBYTES*8-1:0] det_pad;
  logic          last_pos, accept;

  cmd_decoder #(.NKEYS(NKEYS), .KW(KW), .IW(IW), .KBYTES(KBYTES)) u_dec (
    .cmd(rx_byte), .kind(dec_kind), .ndata(dec_ndata), .key(dec_key));

  touch_summary #(.NKEYS(NKEYS)) u_sum (.det(key_detect), .summary(ovr_byte));

  assign accept    = rx_valid && (state == ST_IDLE || (state == ST_SEND && last_pos));
  assign last_pos  = (idx == ndata_r + IW'(1));
  assign fold_in   = accept ? 16'h0000 : crc;
  assign fold_byte = accept ? rx_byte : resp[idx];
  assign det_pad   = (KBYTES*8)'(key_detect);

  crc16_fold #(.POLY(POLY)) u_crc (.crc_in(fold_in), .data_in(fold_byte), .crc_out(fold_out));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      kind_r  <= K_NONE;
      ndata_r <= '0;
      idx     <= '0;
      crc     <= '0;
      key_sel <= '0;
      tx_byte <= 8'h00;
      ready   <= 1'b1;
    end else if (accept) begin
      ready <= 1'b0;
      if (dec_kind != K_NONE) begin
        kind_r  <= dec_kind;
        ndata_r <= dec_ndata;
        crc     <= fold_out;
        if (dec_kind == K_KEY) key_sel <= dec_key;
        state   <= ST_LOAD;
      end else begin
        state   <= ST_IDLE;
        tx_byte <= 8'h00;
      end
    end else begin
      case (state)
        ST_IDLE: begin
          ready   <= !rx_valid;
          tx_byte <= 8'h00;
        end
        ST_LOAD: begin
          case (kind_r)
            K_OVR: begin
              resp[0] <= status_byte;
              resp[1] <= ovr_byte;
              resp[2] <= tick_count;
              resp[3] <= scan_count;
              resp[4] <= fail_count;
            end
            K_ALL: begin
              for (int j = 0; j < KBYTES; j++) resp[j] <= det_pad[8*j +: 8];
            end
            default: begin
              resp[0] <= key_signal[7:0];
              resp[1] <= key_signal[15:8];
              resp[2] <= key_ref[7:0];
              resp[3] <= key_ref[15:8];
              resp[4] <= key_integ;
            end
          endcase
          idx   <= '0;
          state <= ST_CRC;
        end
        ST_CRC: begin
          crc <= fold_out;
          idx <= idx + IW'(1);
          if (idx == ndata_r - IW'(1)) state <= ST_FIN;
        end
        ST_FIN: begin
          resp[ndata_r]          <= crc[7:0];
          resp[ndata_r + IW'(1)] <= crc[15:8];
          idx   <= '0;
          state <= ST_ADV;
        end
        ST_ADV: begin
          tx_byte <= resp[idx];
          ready   <= 1'b1;
          state   <= ST_SEND;
        end
        ST_SEND: begin
          if (rx_valid) begin
            ready <= 1'b0;
            idx   <= idx + IW'(1);
            state <= ST_ADV;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_ready_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && state != ST_ADV) |=> !ready);

  p_ready_state_r2: assert property (@(posedge clk) disable iff (rst)
    ready |-> (state == ST_IDLE || state == ST_SEND));

  p_tx_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEND && !rx_valid) |=> $stable(tx_byte));

  p_idx_range_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEND) |-> (idx <= ndata_r + IW'(1)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && $past(state) == ST_IDLE && !$past(rx_valid)) |-> (tx_byte == 8'h00));
endmodule

// File: tb/test_spi_cmd_engine.sv
module test_spi_cmd_engine;
  localparam int NKEYS  = 48;
  localparam int KBYTES = (NKEYS + 7) / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [7:0] status_byte = 8'h00, tick_count = 8'h00, scan_count = 8'h00, fail_count = 8'h00;
  logic [NKEYS-1:0] key_detect = '0;
  logic [5:0] key_sel;
  logic [15:0] key_signal, key_ref;
  logic [7:0] key_integ, tx_byte;
  logic ready;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_b [16];
  int exp_n;

  always #5 clk = ~clk;

  assign key_signal = 16'h1234 + 16'(key_sel) * 16'd517;
  assign key_ref    = 16'hA0F0 - 16'(key_sel) * 16'd263;
  assign key_integ  = 8'(key_sel) ^ 8'h5A;

  spi_cmd_engine #(.NKEYS(NKEYS)) i_spi_cmd_engine (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .status_byte(status_byte), .tick_count(tick_count), .scan_count(scan_count),
    .fail_count(fail_count), .key_detect(key_detect), .key_sel(key_sel),
    .key_signal(key_signal), .key_ref(key_ref), .key_integ(key_integ),
    .tx_byte(tx_byte), .ready(ready));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] crc_b(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  function automatic logic [7:0] touch_exp(input logic [NKEYS-1:0] d);
    int n;
    int f;
    n = 0;
    f = -1;
    for (int i = 0; i < NKEYS; i++)
      if (d[i]) begin
        n++;
        if (f < 0) f = i;
      end
    if (n > 3) n = 3;
    if (f < 0) f = 0;
    return {2'(n), 6'(f)};
  endfunction

  // Builds the expected data bytes and the trailing CRC for a command.
  task automatic build_exp(input logic [7:0] cmd);
    logic [15:0] c;
    int k;
    logic [15:0] s;
    logic [15:0] r;
    exp_n = 0;
    if (cmd == 8'h06) begin
      exp_b[0] = status_byte;
      exp_b[1] = touch_exp(key_detect);
      exp_b[2] = tick_count;
      exp_b[3] = scan_count;
      exp_b[4] = fail_count;
      exp_n = 5;
    end else if (cmd == 8'h07) begin
      for (int j = 0; j < KBYTES; j++)
        for (int i = 0; i < 8; i++)
          exp_b[j][i] = (8*j + i < NKEYS) ? key_detect[8*j + i] : 1'b0;
      exp_n = KBYTES;
    end else begin
      k = int'(cmd) - 64;
      s = 16'h1234 + 16'(k) * 16'd517;
      r = 16'hA0F0 - 16'(k) * 16'd263;
      exp_b[0] = s[7:0];
      exp_b[1] = s[15:8];
      exp_b[2] = r[7:0];
      exp_b[3] = r[15:8];
      exp_b[4] = 8'(k) ^ 8'h5A;
      exp_n = 5;
    end
    c = crc_b(16'h0000, cmd);
    for (int i = 0; i < exp_n; i++) c = crc_b(c, exp_b[i]);
    exp_b[exp_n]     = c[7:0];
    exp_b[exp_n + 1] = c[15:8];
    exp_n += 2;
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] got);
    int n;
    @(negedge clk);
    got = tx_byte;
    rx_byte = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_byte = 8'h00;
    check("R2 ready low after byte", 32'(ready), 32'd0);
    n = 0;
    while (!ready && n < 40) begin
      @(negedge clk);
      n++;
    end
    if (!ready) check("R2 ready returns", 32'(ready), 32'd1);
  endtask

  // Reads a response whose command was already accepted.
  task automatic read_resp(input logic [7:0] cmd, input string req, input logic [7:0] junk,
                           input logic [7:0] last_b);
    logic [7:0] got;
    build_exp(cmd);
    for (int i = 0; i < exp_n; i++) begin
      xfer((i == exp_n - 1) ? last_b : junk, got);
      if (i >= exp_n - 2) check("R3 crc byte", 32'(got), 32'(exp_b[i]));
      else                check(req, 32'(got), 32'(exp_b[i]));
    end
  endtask

  task automatic run_cmd(input logic [7:0] cmd, input string req, input logic [7:0] junk);
    logic [7:0] got;
    xfer(cmd, got);
    read_resp(cmd, req, junk, 8'h00);
  endtask

  logic [7:0] g;
  logic [31:0] lcg;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset ready", 32'(ready), 32'd1);
    check("R1 reset tx_byte", 32'(tx_byte), 32'h00);

    // R10: null and unknown bytes in idle give nothing
    xfer(8'h00, g);
    check("R10 idle tx after null", 32'(tx_byte), 32'h00);
    xfer(8'h05, g);
    check("R10 idle tx after unknown", 32'(tx_byte), 32'h00);
    xfer(8'h40 + 8'(NKEYS), g);
    check("R10 out of range key", 32'(tx_byte), 32'h00);
    xfer(8'hFF, g);
    xfer(8'h00, g);
    check("R10 nothing shifted", 32'(g), 32'h00);

    // R7: every per-key command
    for (int k = 0; k < NKEYS; k++) begin
      run_cmd(8'h40 + 8'(k), "R7 per-key data", 8'h00);
      check("R7 key_sel", 32'(key_sel), 32'(k));
    end

    // R4, R5, R6: detect patterns
    for (int p = 0; p < 2 + NKEYS + NKEYS / 2; p++) begin
      if (p == 0) key_detect = '0;
      else if (p == 1) key_detect = '1;
      else if (p < 2 + NKEYS) key_detect = NKEYS'(1) << (p - 2);
      else key_detect = (NKEYS'(1) << (p - 2 - NKEYS)) | (NKEYS'(1) << (NKEYS - 1 - (p - 2 - NKEYS)));
      status_byte = 8'(p * 3 + 1);
      tick_count  = 8'(p * 7);
      scan_count  = 8'(255 - p);
      fail_count  = 8'(p ^ 8'hC3);
      run_cmd(8'h06, "R4 R5 overview", 8'h00);
      run_cmd(8'h07, "R6 all keys", 8'h00);
    end

    // R8: non-null bytes at intermediate positions are ignored
    lcg = 32'h1357_9BDF;
    for (int t = 0; t < 8; t++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      key_detect = {lcg[15:0], lcg};
      run_cmd(8'h07, "R8 junk ignored all keys", 8'h06);
      run_cmd(8'h06, "R8 junk ignored overview", 8'h45);
      run_cmd(8'h40 + 8'(t * 5), "R8 junk ignored per-key", 8'h07);
    end

    // R9: chained commands on the last byte
    xfer(8'h06, g);
    read_resp(8'h06, "R9 chain first", 8'h00, 8'h07);
    read_resp(8'h07, "R9 chain second", 8'h00, 8'h4B);
    read_resp(8'h4B, "R9 chain third", 8'h00, 8'h05);
    check("R10 unknown on last byte", 32'(tx_byte), 32'h00);
    xfer(8'h00, g);
    check("R10 idle after unknown last", 32'(g), 32'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule